// File: doc/BRIEF.md
# Prescaled Countdown Timer

A single-channel down-counting timer that sits behind a plain 32-bit register bus. Software programs an interval, picks one of two tick strobes as the count source, and sets a power-of-two prescaler and a run bit. On each prescaled tick the counter steps down by one. The tick that takes the counter from one to zero is an expiry. An expiry sets a sticky status flag. In periodic mode the counter then refills from the interval register. In single-shot mode the channel stops.

Software can load the counter directly to schedule the next expiry. It can also ask for a refill from the interval register through a self-clearing control bit. The interrupt line is a level: it stays high while the status flag is set and the global interrupt enable is on. Writing one to the status flag clears it.

The bus has no handshake. A write lands on the clock edge where write enable is high. Read data is combinational and is valid in the same cycle as read enable. The tick inputs are one-cycle enable strobes that stand in for two oscillators.

Top module: `cd_timer`

## Requirements
- R1: After reset every register reads zero and irq is low. Reads of any offset other than 0x00, 0x04, 0x10, 0x14 and 0x18 return zero, and writes to them change nothing.
- R2: Register map. Offset 0x00 holds the interrupt enable in bit 0. Offset 0x04 holds the status flag in bit 0. Offset 0x10 holds the control byte in bits 7:0, and its upper bits read zero. Offset 0x14 holds the interval and offset 0x18 holds the counter, both full width and both read back as written.
- R3: Control bits 3:2 choose the count source. Code 0 counts tick_lo strobes, code 1 counts tick_hi strobes (the main oscillator), and codes 2 and 3 count nothing.
- R4: Control bits 6:4 hold a code n. The counter steps once per 2^n strobes of the selected source, counted from the last write to the control register. The 2^n-th strobe gives the first step.
- R5: While control bit 0 (run) is one, each prescaled tick lowers a nonzero counter by one. While run is zero, the counter holds.
- R6: A tick that finds the counter at 1 is an expiry and sets the status flag. In periodic mode (control bit 7 is zero) the counter becomes the interval value.
- R7: In single-shot mode (control bit 7 is one), an expiry leaves the counter at 0 and clears the run bit. A counter loaded with 1 yields exactly one expiry.
- R8: Writing control bit 1 as one requests a refill. It reads back as one until the next clock edge, which copies the interval into the counter and clears the bit.
- R9: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R10: irq is high exactly when the status flag and the interrupt enable are both set.
- R11: A bus write to the counter takes effect on that edge. It overrides both a refill and a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_lo | input | 1 | Count strobe, source code 0 |
| tick_hi | input | 1 | Count strobe, source code 1 (main oscillator) |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 32 | Read data, zero when bus_rd_en is low |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit offset, a 32-bit counter and a 3-bit prescaler code. With these values the largest divide, 128, takes only a few hundred cycles, so the bench reaches the last strobe before an expiry and the expiry strobe itself. The full-width counter lets the register readback use patterns in the upper bits. The small offset space lets the bench probe the unmapped holes between and after the five registers.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam logic [7:0] OFS_GIE  = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_CTL  = 8'h10;
  localparam logic [7:0] OFS_IVAL = 8'h14;
  localparam logic [7:0] OFS_CNT  = 8'h18;

  localparam int unsigned CTL_W = 8;

  // Control byte, MSB first; bit positions are software-visible.
  typedef struct packed {
    logic       one_shot;  // 7
    logic [2:0] div_code;  // 6:4
    logic [1:0] src_sel;   // 3:2
    logic       reload;    // 1
    logic       run;       // 0
  } ctl_t;

  localparam logic [1:0] SRC_LO = 2'd0;
  localparam logic [1:0] SRC_HI = 2'd1;
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
  parameter int unsigned PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [1:0]       src_sel,
  input  logic [PRE_W-1:0] div_code,
  input  logic             strobe_lo,
  input  logic             strobe_hi,
  output logic             tick
);
  import tmr_pkg::*;

  localparam int unsigned DIV_W = (1 << PRE_W) - 1;

  logic             src_pulse;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] mask;

  always_comb begin
    unique case (src_sel)
      SRC_LO:  src_pulse = strobe_lo;
      SRC_HI:  src_pulse = strobe_hi;
      default: src_pulse = 1'b0;
    endcase
  end

  // mask has div_code low ones: a tick every 2^div_code strobes
  for (genvar gi = 0; gi < DIV_W; gi++) begin : g_mask
    assign mask[gi] = (PRE_W'(gi) < div_code);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                div_cnt <= '0;
    else if (restart || !run)  div_cnt <= '0;
    else if (src_pulse)        div_cnt <= div_cnt + 1'b1;
  end

  assign tick = run && src_pulse && ((div_cnt & mask) == mask);

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_code != '0) |=> !tick); // R4
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             one_shot,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  input  logic             reload,
  input  logic [CNT_W-1:0] interval,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic step;
  assign step   = tick && run && !load_we && !reload;
  assign expire = step && (count == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)            count <= '0;
    else if (load_we)      count <= load_val;
    else if (reload)       count <= interval;
    else if (expire)       count <= one_shot ? '0 : interval;
    else if (step && count != '0) count <= count - 1'b1;
  end

  AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> count == $past(load_val)); // R11
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count > CNT_W'(1)) |=> count == $past(count) - 1'b1); // R5
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_we && !reload) |=> $stable(count)); // R5
endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [31:0]       bus_wr_data,
  input  logic              bus_rd_en,
  output logic [31:0]       bus_rd_data,
  input  logic              expire,
  input  logic [CNT_W-1:0]  count,
  output tmr_pkg::ctl_t     ctl,
  output logic [CNT_W-1:0]  interval,
  output logic              cnt_we,
  output logic [CNT_W-1:0]  cnt_wdata,
  output logic              ctl_we,
  output logic              irq
);
  import tmr_pkg::*;

  logic gie, status;
  logic hit_gie, hit_stat, hit_ctl, hit_ival;

  assign hit_gie  = bus_wr_en && (bus_addr == ADDR_W'(OFS_GIE));
  assign hit_stat = bus_wr_en && (bus_addr == ADDR_W'(OFS_STAT));
  assign hit_ctl  = bus_wr_en && (bus_addr == ADDR_W'(OFS_CTL));
  assign hit_ival = bus_wr_en && (bus_addr == ADDR_W'(OFS_IVAL));
  assign cnt_we   = bus_wr_en && (bus_addr == ADDR_W'(OFS_CNT));
  assign cnt_wdata = bus_wr_data[CNT_W-1:0];
  assign ctl_we   = hit_ctl;

  always_ff @(posedge clk) begin
    if (!rst_n)        gie <= 1'b0;
    else if (hit_gie)  gie <= bus_wr_data[0];
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n)                           status <= 1'b0;
    else if (expire)                      status <= 1'b1;
    else if (hit_stat && bus_wr_data[0])  status <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl <= '0;
    else if (hit_ctl) ctl <= ctl_t'(bus_wr_data[CTL_W-1:0]);
    else begin
      if (ctl.reload)             ctl.reload <= 1'b0;
      if (expire && ctl.one_shot) ctl.run    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        interval <= '0;
    else if (hit_ival) interval <= bus_wr_data[CNT_W-1:0];
  end

  always_comb begin
    bus_rd_data = '0;
    if (bus_rd_en) begin
      unique case (bus_addr)
        ADDR_W'(OFS_GIE):  bus_rd_data = {31'b0, gie};
        ADDR_W'(OFS_STAT): bus_rd_data = {31'b0, status};
        ADDR_W'(OFS_CTL):  bus_rd_data = {{(32-CTL_W){1'b0}}, ctl};
        ADDR_W'(OFS_IVAL): bus_rd_data = 32'(interval);
        ADDR_W'(OFS_CNT):  bus_rd_data = 32'(count);
        default:           bus_rd_data = '0;
      endcase
    end
  end

  assign irq = status && gie;

  AST_EXPIRE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> status); // R6
  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctl.one_shot && !hit_ctl) |=> !ctl.run); // R7
  AST_RELOAD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.reload && !hit_ctl) |=> !ctl.reload); // R8
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_stat && bus_wr_data[0] && !expire) |=> !status); // R9
endmodule

// File: rtl/cd_timer.sv
`timescale 1ns/1ps
module cd_timer #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PRE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_lo,
  input  logic              tick_hi,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [31:0]       bus_wr_data,
  input  logic              bus_rd_en,
  output logic [31:0]       bus_rd_data,
  output logic              irq
);
  import tmr_pkg::*;

  ctl_t             ctl;
  logic [CNT_W-1:0] interval, count, cnt_wdata;
  logic             cnt_we, ctl_we, expire, tick;

  tmr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
    .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
    .expire(expire), .count(count), .ctl(ctl), .interval(interval),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .ctl_we(ctl_we), .irq(irq)
  );

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctl.run), .restart(ctl_we),
    .src_sel(ctl.src_sel), .div_code(ctl.div_code[PRE_W-1:0]),
    .strobe_lo(tick_lo), .strobe_hi(tick_hi), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctl.run),
    .one_shot(ctl.one_shot), .load_we(cnt_we), .load_val(cnt_wdata),
    .reload(ctl.reload), .interval(interval), .count(count), .expire(expire)
  );
endmodule

// File: tb/test_cd_timer.sv
`timescale 1ns/1ps
module test_cd_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_lo = 1'b0, tick_hi = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [31:0] bus_wr_data = '0;
  logic [31:0] bus_rd_data;
  logic        irq;
  int          errors = 0, checks = 0;

  localparam logic [7:0] A_GIE = 8'h00, A_STAT = 8'h04, A_CTL = 8'h10,
                         A_IVAL = 8'h14, A_CNT = 8'h18;

  cd_timer i_cd_timer (
    .clk(clk), .rst_n(rst_n), .tick_lo(tick_lo), .tick_hi(tick_hi),
    .bus_addr(bus_addr), .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
    .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    bus_addr = a; bus_rd_en = 1'b1;
    #0.5;
    v = bus_rd_data;
    bus_rd_en = 1'b0;
    check(req, v, exp);
  endtask

  task automatic pulse(bit hi, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (hi) tick_hi = 1'b1; else tick_lo = 1'b1;
      @(negedge clk);
      tick_hi = 1'b0; tick_lo = 1'b0;
    end
  endtask

  task automatic t_reset();
    rd_chk("R1 gie", A_GIE, 0);
    rd_chk("R1 stat", A_STAT, 0);
    rd_chk("R1 ctl", A_CTL, 0);
    rd_chk("R1 ival", A_IVAL, 0);
    rd_chk("R1 cnt", A_CNT, 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_map();
    wr(A_GIE, 32'hFFFF_FFFF);   rd_chk("R2 gie", A_GIE, 1);
    wr(A_IVAL, 32'h1234_5678);  rd_chk("R2 ival", A_IVAL, 32'h1234_5678);
    wr(A_CNT, 32'hA5A5_00A5);   rd_chk("R2 cnt", A_CNT, 32'hA5A5_00A5);
    wr(A_CTL, 32'hFFFF_FF4C);   rd_chk("R2 ctl", A_CTL, 32'h4C);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h0);
    rd_chk("R1 hole 08", 8'h08, 0);
    rd_chk("R1 hole 0C", 8'h0C, 0);
    rd_chk("R1 hole 1C", 8'h1C, 0);
    rd_chk("R1 gie kept", A_GIE, 1);
    rd_chk("R1 ival kept", A_IVAL, 32'h1234_5678);
    wr(A_CTL, 0); wr(A_GIE, 0);
  endtask

  task automatic t_source();
    wr(A_CNT, 10); wr(A_CTL, 32'h01);
    pulse(1, 3); rd_chk("R3 src0 ignores hi", A_CNT, 10);
    pulse(0, 3); rd_chk("R3 src0 counts lo", A_CNT, 7);
    wr(A_CTL, 32'h05);
    pulse(0, 2); rd_chk("R3 src1 ignores lo", A_CNT, 7);
    pulse(1, 2); rd_chk("R3 src1 counts hi", A_CNT, 5);
    wr(A_CTL, 32'h09);
    pulse(0, 2); pulse(1, 2); rd_chk("R3 src2 counts none", A_CNT, 5);
    wr(A_CTL, 32'h04);
    pulse(1, 3); rd_chk("R5 stopped holds", A_CNT, 5);
  endtask

  task automatic t_periodic();
    wr(A_IVAL, 3); wr(A_CNT, 3); wr(A_GIE, 1); wr(A_CTL, 32'h25);
    pulse(1, 11);
    rd_chk("R4 div4 after 11", A_CNT, 1);
    rd_chk("R6 no early flag", A_STAT, 0);
    pulse(1, 1);
    rd_chk("R6 flag set", A_STAT, 1);
    rd_chk("R6 periodic refill", A_CNT, 3);
    rd_chk("R6 run kept", A_CTL, 32'h25);
    check("R10 irq high", 32'(irq), 1);
    wr(A_GIE, 0);
    check("R10 irq gated", 32'(irq), 0);
    wr(A_STAT, 0); rd_chk("R9 write zero no effect", A_STAT, 1);
    wr(A_STAT, 1); rd_chk("R9 w1c", A_STAT, 0);
    wr(A_CTL, 0);
  endtask

  task automatic t_oneshot();
    wr(A_GIE, 1); wr(A_IVAL, 5); wr(A_CNT, 1); wr(A_CTL, 32'h85);
    pulse(1, 1);
    rd_chk("R7 flag", A_STAT, 1);
    check("R10 irq", 32'(irq), 1);
    rd_chk("R7 run cleared", A_CTL, 32'h84);
    rd_chk("R7 count zero", A_CNT, 0);
    wr(A_STAT, 1);
    pulse(1, 4);
    rd_chk("R7 single expiry", A_STAT, 0);
    rd_chk("R7 count stays", A_CNT, 0);
  endtask

  task automatic t_div128();
    wr(A_CNT, 1); wr(A_CTL, 32'hF1);
    pulse(0, 127);
    rd_chk("R4 div128 before", A_STAT, 0);
    rd_chk("R4 div128 count", A_CNT, 1);
    pulse(0, 1);
    rd_chk("R4 div128 expiry", A_STAT, 1);
    wr(A_STAT, 1);
  endtask

  task automatic t_reload();
    wr(A_IVAL, 9); wr(A_CTL, 32'h02);
    rd_chk("R8 bit visible", A_CTL, 32'h02);
    @(negedge clk);
    rd_chk("R8 bit cleared", A_CTL, 0);
    rd_chk("R8 refilled", A_CNT, 9);
  endtask

  task automatic t_direct();
    wr(A_IVAL, 50); wr(A_CNT, 4); wr(A_CTL, 32'h05);
    pulse(1, 2); rd_chk("R11 pre", A_CNT, 2);
    wr(A_CNT, 7); rd_chk("R11 direct write", A_CNT, 7);
    pulse(1, 7);
    rd_chk("R11 expiry after 7", A_STAT, 1);
    rd_chk("R6 refill 50", A_CNT, 50);
    wr(A_STAT, 1);
    wr(A_CNT, 1);
    // tick and w1c in the same cycle: set wins
    @(negedge clk);
    bus_addr = A_STAT; bus_wr_data = 1; bus_wr_en = 1'b1; tick_hi = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0; tick_hi = 1'b0;
    rd_chk("R9 set beats clear", A_STAT, 1);
    // write to counter in the same cycle as a tick: write wins
    wr(A_STAT, 1); wr(A_CNT, 20);
    @(negedge clk);
    bus_addr = A_CNT; bus_wr_data = 33; bus_wr_en = 1'b1; tick_hi = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0; tick_hi = 1'b0;
    rd_chk("R11 write beats tick", A_CNT, 33);
    wr(A_CTL, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_source();
    t_periodic();
    t_oneshot();
    t_div128();
    t_reload();
    t_direct();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule